// File: doc/BRIEF.md
# ADC Conversion Handshake Sequencer

This block is the digital control sequencer of a parallel-bus analog-to-digital converter. It watches active-low chip-select, read and write strobes. It tells an abstract converter core when to start a conversion. The core answers with an 8-bit result and a one-cycle done flag. The block then decides when that result is strobed into the output register and when the interrupt is raised. It also controls when the data outputs are enabled and when the open-drain ready line is pulled low.

A static mode input picks one of two handshakes:

- **Read-only mode** (`modeSel` low, which is the intended tie-off). A falling read starts a conversion. The ready line signals busy until the result is in.
- **Write-read mode** (`modeSel` high). A write pulse samples the input. A count-down measured from the end of the write then completes the conversion. An early read cuts this count-down short.

All bus inputs pass through a synchroniser of `SYNC_STAGES` flops before the edge logic sees them. Every interval is counted in clock cycles set by parameters:

| Parameter | Meaning |
|---|---|
| `CONV_CYCLES` | Worst-case conversion bound in read-only mode |
| `COUNTDOWN_CYCLES` | Write-read count-down |
| `EARLY_INT_CYCLES` | Interrupt delay after an early read |
| `RECOVERY_CYCLES` | Minimum gap between a latch and the next start |

The open-drain ready pin is modelled as a drive-low enable. The tri-state data bus is modelled as a value plus an output enable.

Top module: `adc_handshake_seq`

## Requirements
- R1: `modeSel`=0 selects read-only mode and `modeSel`=1 selects write-read mode. In read-only mode a write pulse starts nothing. In write-read mode a read falling edge on its own starts nothing.
- R2: While `csN` is high, edges on `rdN` and `wrN` are ignored: no `coreStart`, `intN` stays high and `dataOe` stays low.
- R3: In read-only mode, a falling `rdN` with `csN` low issues a one-cycle `coreStart`. `rdyDriveLow` is 1 while that conversion is in progress and `csN` is low.
- R4: In read-only mode the conversion completes at the first of two events: the cycle after `coreDone`, or `CONV_CYCLES` cycles after the `coreStart` cycle. On completion the following all happen:
  - `intN` falls (it is 0 from the `coreStart` cycle plus min(L+1, `CONV_CYCLES`), where L is the distance to `coreDone`);
  - `rdyDriveLow` is released;
  - `dataOe` is 1 while `rdN` and `csN` are low;
  - `dataOut` holds the latest core result.
- R5: In write-read mode, a write pulse with `csN` low issues `coreStart` only after `wrN` rises. Exactly `COUNTDOWN_CYCLES` cycles after the `coreStart` cycle, `latchStrobe` pulses and `intN` falls in the same cycle, and `dataOut` then holds the latest core result.
- R6: In write-read mode, a falling `rdN` during the count-down latches the result at once. `intN` falls exactly `EARLY_INT_CYCLES` cycles after the `latchStrobe` cycle, before the count-down would have ended.
- R7: In write-read mode, `dataOe` is 1 exactly while `csN` and `rdN` are both low (after synchroniser delay), whatever the conversion state.
- R8: `intN` is high after reset. `intN` returns high after a rising `rdN` (with `csN` low) or a rising `csN`. `dataOe` is 0 once the read ends.
- R9: Stand-alone use: with `csN` and `rdN` held low in write-read mode, each write pulse launches a conversion. `intN` returns high while `wrN` is low and falls again `COUNTDOWN_CYCLES` after the new `coreStart`.
- R10: A start request that arrives while a conversion is in progress is ignored. `coreStart` is never high for two cycles in a row.
- R11: A start request that arrives within `RECOVERY_CYCLES` cycles of a latch is ignored.
- R12: `latchStrobe` is a one-cycle pulse. `dataOut` changes only in the cycle after a latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0 = read-only mode, 1 = write-read mode |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe (write-read mode) |
| coreResult | input | 8 | Conversion result from the converter core |
| coreDone | input | 1 | One-cycle flag: `coreResult` is valid |
| coreStart | output | 1 | One-cycle start pulse to the converter core |
| rdyDriveLow | output | 1 | 1 pulls the open-drain ready line low (busy) |
| intN | output | 1 | Active-low interrupt: result latched |
| latchStrobe | output | 1 | One-cycle pulse when the output register loads |
| dataOe | output | 1 | Output enable for the tri-state data bus |
| dataOut | output | 8 | Latched conversion result |

## Verification
The assertions assume the following about the environment:

- Every strobe level is held for longer than the synchroniser depth plus one cycle, so no edge is lost or merged.
- `modeSel` does not change while a transaction is open.
- `coreDone` is a single-cycle pulse that arrives only after a `coreStart`.

The stimulus keeps within these limits in three ways:

- Every strobe level is held for at least three cycles.
- The mode and chip select change only between transactions.
- The core is modelled as one pending request at a time, with its latency drawn from a seeded generator and kept below the count-down. The exception is the timeout case, where the core is silenced completely.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RO_BUSY,
    ST_WR_SAMPLE,
    ST_WR_COUNT,
    ST_WR_EARLY,
    ST_RESULT
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchNow;
    logic outEnable;
  } dpStrobe_t;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[0] <= RESET_VAL;
        else       pipe[0] <= din;
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RESET_VAL}};
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 625,
  parameter int COUNTDOWN_CYCLES = 200,
  parameter int EARLY_INT_CYCLES = 4,
  parameter int RECOVERY_CYCLES = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeS,
  input  logic       csS,
  input  logic       rdS,
  input  logic       wrS,
  input  logic       coreDone,
  output logic       coreStart,
  output logic       rdyDriveLow,
  output logic       intN,
  output logic       latchStrobe,
  output dpStrobe_t  strobe
);

  localparam int MAX_A   = (CONV_CYCLES > COUNTDOWN_CYCLES) ? CONV_CYCLES : COUNTDOWN_CYCLES;
  localparam int MAX_CNT = (MAX_A > EARLY_INT_CYCLES) ? MAX_A : EARLY_INT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int REC_W   = $clog2(RECOVERY_CYCLES + 2);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] CD_LAST    = CNT_W'(COUNTDOWN_CYCLES - 1);
  localparam logic [CNT_W-1:0] EARLY_LAST = CNT_W'(EARLY_INT_CYCLES - 1);
  localparam logic [REC_W-1:0] REC_LOAD   = REC_W'(RECOVERY_CYCLES);

  seqState_t st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [REC_W-1:0] recCnt;
  logic rdPrev, wrPrev, csPrev;
  logic startNow, latchNow;
  logic csAct, recIdle;
  logic rdFall, rdRise, wrFall, wrRise, csRise;

  assign csAct   = ~csS;
  assign recIdle = (recCnt == '0);
  assign rdFall  = rdPrev & ~rdS;
  assign rdRise  = ~rdPrev & rdS;
  assign wrFall  = wrPrev & ~wrS;
  assign wrRise  = ~wrPrev & wrS;
  assign csRise  = ~csPrev & csS;

  always_comb begin
    stNext   = st;
    startNow = 1'b0;
    latchNow = 1'b0;
    cntNext  = cnt + 1'b1;
    unique case (st)
      ST_IDLE: begin
        if (csAct && recIdle) begin
          if (!modeS && rdFall) begin
            startNow = 1'b1;
            stNext   = ST_RO_BUSY;
          end else if (modeS && wrFall) begin
            stNext = ST_WR_SAMPLE;
          end
        end
      end
      ST_RO_BUSY: begin
        if (coreDone || cnt == CONV_LAST) begin
          latchNow = 1'b1;
          stNext   = ST_RESULT;
        end
      end
      ST_WR_SAMPLE: begin
        if (!csAct) begin
          stNext = ST_IDLE;
        end else if (wrRise) begin
          startNow = 1'b1;
          stNext   = ST_WR_COUNT;
        end
      end
      ST_WR_COUNT: begin
        if (csAct && rdFall) begin
          latchNow = 1'b1;
          stNext   = ST_WR_EARLY;
        end else if (cnt == CD_LAST) begin
          latchNow = 1'b1;
          stNext   = ST_RESULT;
        end
      end
      ST_WR_EARLY: begin
        if (rdRise || csRise) begin
          stNext = ST_IDLE;
        end else if (cnt == EARLY_LAST) begin
          stNext = ST_RESULT;
        end
      end
      ST_RESULT: begin
        if ((csAct && rdRise) || csRise) begin
          stNext = ST_IDLE;
        end else if (modeS && csAct && wrFall && recIdle) begin
          stNext = ST_WR_SAMPLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
    if (stNext != st) cntNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      recCnt      <= '0;
      rdPrev      <= 1'b1;
      wrPrev      <= 1'b1;
      csPrev      <= 1'b1;
      coreStart   <= 1'b0;
      latchStrobe <= 1'b0;
    end else begin
      st          <= stNext;
      cnt         <= cntNext;
      rdPrev      <= rdS;
      wrPrev      <= wrS;
      csPrev      <= csS;
      coreStart   <= startNow;
      latchStrobe <= latchNow;
      if (latchNow)     recCnt <= REC_LOAD;
      else if (!recIdle) recCnt <= recCnt - 1'b1;
    end
  end

  assign rdyDriveLow      = (st == ST_RO_BUSY) && csAct;
  assign intN             = (st != ST_RESULT);
  assign strobe.latchNow  = latchNow;
  assign strobe.outEnable = modeS ? (csAct && !rdS)
                                  : ((st == ST_RESULT) && csAct && !rdS);

  // R10: start is a single-cycle pulse
  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> !coreStart);

  // R11: no start inside the recovery window
  assert_recovery_gap_R11: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |-> $past(recCnt) == '0);

  // R2: a start needs chip select active on the deciding cycle
  assert_start_needs_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |-> $past(!csS));

  // R4: ready busy and interrupt are never both asserted
  assert_rdy_int_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdyDriveLow |-> intN);

  // R12: latch strobe never lasts two cycles
  assert_latch_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |=> !latchStrobe);

endmodule

// File: rtl/adc_seq_data.sv
module adc_seq_data
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreDone,
  input  logic [DATA_W-1:0] coreResult,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic [DATA_W-1:0] holdReg, outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      outReg  <= '0;
    end else begin
      if (coreDone) holdReg <= coreResult;
      if (strobe.latchNow) outReg <= coreDone ? coreResult : holdReg;
    end
  end

  assign dataOut = outReg;
  assign dataOe  = strobe.outEnable;

  // R12: output register moves only on a latch
  assert_hold_between_latches_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.latchNow) |-> $stable(outReg));

endmodule

// File: rtl/adc_handshake_seq.sv
module adc_handshake_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYCLES = 625,
  parameter int COUNTDOWN_CYCLES = 200,
  parameter int EARLY_INT_CYCLES = 4,
  parameter int RECOVERY_CYCLES = 125
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] coreResult,
  input  logic              coreDone,
  output logic              coreStart,
  output logic              rdyDriveLow,
  output logic              intN,
  output logic              latchStrobe,
  output logic              dataOe,
  output logic [DATA_W-1:0] dataOut
);

  logic [3:0] busSync;
  dpStrobe_t  strobe;

  adc_seq_sync #(
    .STAGES   (SYNC_STAGES),
    .WIDTH    (4),
    .RESET_VAL(4'b0111)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({modeSel, csN, rdN, wrN}),
    .dout(busSync)
  );

  adc_seq_ctrl #(
    .CONV_CYCLES     (CONV_CYCLES),
    .COUNTDOWN_CYCLES(COUNTDOWN_CYCLES),
    .EARLY_INT_CYCLES(EARLY_INT_CYCLES),
    .RECOVERY_CYCLES (RECOVERY_CYCLES)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeS      (busSync[3]),
    .csS        (busSync[2]),
    .rdS        (busSync[1]),
    .wrS        (busSync[0]),
    .coreDone   (coreDone),
    .coreStart  (coreStart),
    .rdyDriveLow(rdyDriveLow),
    .intN       (intN),
    .latchStrobe(latchStrobe),
    .strobe     (strobe)
  );

  adc_seq_data #(
    .DATA_W(DATA_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .coreDone  (coreDone),
    .coreResult(coreResult),
    .strobe    (strobe),
    .dataOut   (dataOut),
    .dataOe    (dataOe)
  );

endmodule

// File: tb/adc_handshake_seq_test.sv
`timescale 1ns/1ps
module adc_handshake_seq_test;

  localparam int DW   = 8;
  localparam int CONV = 625;
  localparam int CD   = 200;
  localparam int EI   = 4;
  localparam int REC  = 125;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0;
  logic csN = 1'b1;
  logic rdN = 1'b1;
  logic wrN = 1'b1;
  logic coreDone = 1'b0;
  logic [DW-1:0] coreResult = '0;
  logic coreStart, rdyDriveLow, intN, latchStrobe, dataOe;
  logic [DW-1:0] dataOut;

  adc_handshake_seq #(
    .DATA_W(DW), .SYNC_STAGES(2), .CONV_CYCLES(CONV),
    .COUNTDOWN_CYCLES(CD), .EARLY_INT_CYCLES(EI), .RECOVERY_CYCLES(REC)
  ) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .rdN(rdN), .wrN(wrN),
    .coreResult(coreResult), .coreDone(coreDone), .coreStart(coreStart),
    .rdyDriveLow(rdyDriveLow), .intN(intN), .latchStrobe(latchStrobe),
    .dataOe(dataOe), .dataOut(dataOut)
  );

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int cyc = 0, startCount = 0, latchCount = 0, intFallCount = 0;
  int startCyc = 0, latchCyc = 0, intFallCyc = 0;
  bit intPrev = 1'b1;
  int coreLat = 10;
  bit coreOn = 1'b1;
  logic [DW-1:0] lastCoreVal = '0;

  // Event monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (coreStart) begin startCount++; startCyc = cyc; end
      if (latchStrobe) begin latchCount++; latchCyc = cyc; end
      if (intPrev && !intN) begin intFallCount++; intFallCyc = cyc; end
      intPrev = intN;
    end
  end

  // Converter core model: one pending request
  initial begin
    int pend;
    pend = -1;
    forever begin
      @(negedge clk);
      coreDone = 1'b0;
      if (coreStart && coreOn) begin
        pend = coreLat;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          coreResult = DW'($urandom);
          lastCoreVal = coreResult;
          coreDone = 1'b1;
          pend = -1;
        end
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    report();
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int counterOf(input int sel);
    case (sel)
      0: return startCount;
      1: return latchCount;
      default: return intFallCount;
    endcase
  endfunction

  task automatic waitCnt(input int sel, input int prev, input int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (counterOf(sel) > prev) begin ok = 1'b1; break; end
      tick(1);
    end
    if (counterOf(sel) > prev) ok = 1'b1;
  endtask

  function automatic int expReadDelay(input int lat, input bit timeout);
    if (timeout) return CONV;
    return (lat + 1 < CONV) ? lat + 1 : CONV;
  endfunction

  function automatic int expWriteDelay();
    return CD;
  endfunction

  task automatic readOnlyConv(input int lat, input bit timeout);
    int s0, i0; bit ok;
    modeSel = 1'b0; coreOn = !timeout; coreLat = lat;
    csN = 1'b0; tick(4);
    s0 = startCount; i0 = intFallCount;
    rdN = 1'b0;
    waitCnt(0, s0, 10, ok);
    chkEq("R3", "start after read fall", int'(ok), 1);
    tick(1);
    chkEq("R3", "ready held low while busy", rdyDriveLow, 1);
    waitCnt(2, i0, CONV + 10, ok);
    chkEq("R4", "interrupt fell", int'(ok), 1);
    chkEq("R4", "start to interrupt cycles", intFallCyc - startCyc, expReadDelay(lat, timeout));
    chkEq("R4", "ready released", rdyDriveLow, 0);
    tick(1);
    chkEq("R4", "data enabled", dataOe, 1);
    chkEq("R4", "latched data", dataOut, lastCoreVal);
    rdN = 1'b1; tick(5);
    chkEq("R8", "interrupt high after read rise", intN, 1);
    chkEq("R8", "data disabled after read", dataOe, 0);
    csN = 1'b1; tick(REC + 5);
    coreOn = 1'b1;
  endtask

  // kind: 0 read after count-down, 1 early read, 2 chip-select ends
  task automatic writeRead(input int lat, input int kind);
    int s0, l0, i0; bit ok;
    modeSel = 1'b1; coreLat = lat;
    csN = 1'b0; tick(4);
    s0 = startCount; i0 = intFallCount;
    wrN = 1'b0; tick(4);
    chkEq("R5", "no start while write low", startCount, s0);
    wrN = 1'b1;
    waitCnt(0, s0, 10, ok);
    chkEq("R5", "start after write rise", int'(ok), 1);
    if (kind == 1) begin
      tick(lat + 3);
      chkEq("R7", "outputs off before read", dataOe, 0);
      l0 = latchCount;
      rdN = 1'b0;
      waitCnt(1, l0, 10, ok);
      chkEq("R6", "early latch", int'(ok), 1);
      waitCnt(2, i0, EI + 6, ok);
      chkEq("R6", "latch to interrupt cycles", intFallCyc - latchCyc, EI);
      chkEq("R6", "latched before count-down end", int'(latchCyc - startCyc < CD), 1);
      tick(1);
      chkEq("R6", "early data", dataOut, lastCoreVal);
      chkEq("R7", "enabled while reading", dataOe, 1);
    end else begin
      tick(2);
      chkEq("R7", "outputs off in count-down", dataOe, 0);
      waitCnt(2, i0, CD + 10, ok);
      chkEq("R5", "count-down cycles", intFallCyc - startCyc, expWriteDelay());
      chkEq("R5", "latch with interrupt", latchCyc, intFallCyc);
      tick(1);
      chkEq("R12", "latch strobe one cycle", latchStrobe, 0);
      if (kind == 0) begin
        rdN = 1'b0; tick(4);
        chkEq("R7", "enabled while reading", dataOe, 1);
        chkEq("R5", "latched data", dataOut, lastCoreVal);
      end
    end
    if (kind == 2) begin
      csN = 1'b1; tick(5);
      chkEq("R8", "interrupt high after cs rise", intN, 1);
    end else begin
      rdN = 1'b1; tick(5);
      chkEq("R8", "interrupt high after read rise", intN, 1);
      chkEq("R8", "data disabled after read", dataOe, 0);
      csN = 1'b1;
    end
    tick(REC + 5);
  endtask

  initial begin
    bit ok;
    int s0, i0;
    void'($urandom(32'h5eed_0820));
    tick(3);
    chkEq("R8", "interrupt high in reset", intN, 1);
    rstN = 1'b1;
    tick(3);
    chkEq("R8", "interrupt high after reset", intN, 1);
    chkEq("R3", "ready released after reset", rdyDriveLow, 0);
    chkEq("R7", "data off after reset", dataOe, 0);
    chkEq("R10", "no start after reset", coreStart, 0);
    chkEq("R12", "no latch after reset", latchStrobe, 0);

    // R2: strobes with chip select high
    s0 = startCount;
    rdN = 1'b0; tick(6); rdN = 1'b1; tick(4);
    modeSel = 1'b1; tick(4);
    wrN = 1'b0; tick(4); wrN = 1'b1; tick(8);
    chkEq("R2", "no start without cs", startCount, s0);
    chkEq("R2", "interrupt idle without cs", intN, 1);
    chkEq("R2", "data off without cs", dataOe, 0);
    modeSel = 1'b0; tick(4);

    // R1: wrong strobe for the mode
    csN = 1'b0; tick(4);
    wrN = 1'b0; tick(4); wrN = 1'b1; tick(8);
    chkEq("R1", "write ignored in read-only", startCount, s0);
    modeSel = 1'b1; tick(4);
    rdN = 1'b0; tick(6);
    chkEq("R1", "read alone starts nothing in write-read", startCount, s0);
    chkEq("R7", "enabled by read and cs", dataOe, 1);
    rdN = 1'b1; tick(4);
    chkEq("R7", "disabled after read", dataOe, 0);
    csN = 1'b1; tick(4);

    // Directed flows
    readOnlyConv(12, 1'b0);
    readOnlyConv(1, 1'b0);
    writeRead(30, 0);
    writeRead(20, 1);
    writeRead(50, 2);
    readOnlyConv(0, 1'b1);
    chkEq("R12", "data held after timeout read", dataOut, lastCoreVal);

    // R10: write during count-down
    modeSel = 1'b1; coreLat = 20; csN = 1'b0; tick(4);
    s0 = startCount; i0 = intFallCount;
    wrN = 1'b0; tick(4); wrN = 1'b1;
    waitCnt(0, s0, 10, ok);
    tick(30);
    wrN = 1'b0; tick(4); wrN = 1'b1; tick(4);
    waitCnt(2, i0, CD + 10, ok);
    chkEq("R10", "single start for busy write", startCount, s0 + 1);
    chkEq("R10", "count-down unchanged", intFallCyc - startCyc, CD);
    rdN = 1'b0; tick(4); rdN = 1'b1; tick(5); csN = 1'b1; tick(REC + 5);

    // R11: read again inside recovery window
    modeSel = 1'b0; coreLat = 5; csN = 1'b0; tick(4);
    i0 = intFallCount;
    rdN = 1'b0;
    waitCnt(2, i0, 40, ok);
    rdN = 1'b1; tick(4);
    s0 = startCount;
    rdN = 1'b0; tick(20);
    chkEq("R11", "start ignored during recovery", startCount, s0);
    chkEq("R11", "interrupt stays high", intN, 1);
    rdN = 1'b1; csN = 1'b1; tick(REC + 5);

    // R9: stand-alone with cs and rd held low
    modeSel = 1'b1; csN = 1'b0; rdN = 1'b0; tick(4);
    for (int k = 0; k < 2; k++) begin
      coreLat = $urandom_range(5, 100);
      s0 = startCount; i0 = intFallCount;
      wrN = 1'b0; tick(4);
      if (k == 1) chkEq("R9", "interrupt high on new write", intN, 1);
      wrN = 1'b1;
      waitCnt(0, s0, 10, ok);
      waitCnt(2, i0, CD + 10, ok);
      chkEq("R9", "stand-alone count-down", intFallCyc - startCyc, CD);
      tick(1);
      chkEq("R9", "stand-alone data enabled", dataOe, 1);
      chkEq("R9", "stand-alone data", dataOut, lastCoreVal);
      tick(REC + 5);
    end
    rdN = 1'b1; csN = 1'b1; tick(REC);

    // Seeded random mix
    for (int it = 0; it < 24; it++) begin
      int kind;
      kind = $urandom_range(0, 3);
      if (kind == 0) readOnlyConv($urandom_range(1, 80), 1'b0);
      else writeRead($urandom_range(5, 100), kind - 1);
    end

    report();
  end

endmodule